// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Walker

This block moves data from card-side memory to host memory by following a list of scatter-gather descriptors. Software places the list contiguously in memory and writes its base address to the start register. The walker then reads each descriptor as three 32-bit words through a descriptor read port. For each descriptor it copies the requested byte count, one 32-bit beat at a time: it reads a word through a source read port and writes that word through a destination write port.

The walker stops once it completes the descriptor whose last flag is set. It then pulses an interrupt for one cycle and records the outcome in a sticky status register. Software clears a status bit by writing 1 to it.

A malformed descriptor, or an error response on any port, aborts the list at once. The walker sets the matching error bit, pulses the interrupt and goes idle. Each port uses the same handshake: a request with its address, and a response (`*_ack`) that may carry an error flag.

Top module: `sg_walker`

## Requirements
- R1: After reset the walker is idle. The status register reads 0, the interrupt is low, `busy` is low and no port request is asserted.
- R2: A write with `cfg_sel`=0 starts a walk at `cfg_wdata`. Descriptor k is read at base+12k, base+12k+4 and base+12k+8. Word 0 is the source address and word 1 is the destination address. In word 2, bits 15:0 are the byte count and bit 31 is the last flag.
- R3: A descriptor with count N causes N/4 source reads and N/4 destination writes, with one read followed by one write for each beat. Both addresses rise by 4 on each beat, and each destination word equals the source word read for that beat.
- R4: After the descriptor whose bit 31 is set completes, the walker pulses `irq` for exactly one cycle. It then sets status bit 0 (read completed) and bit 1 (write completed), and `busy` falls.
- R5: A byte count of zero, or a count whose bits 7:0 are not all zero, aborts the list. This sets status bit 4 (descriptor error) and pulses `irq`, and that descriptor makes no source read and no destination write.
- R6: An error response on the descriptor port aborts the list with status bit 4 set and `irq` pulsed, and no data is moved.
- R7: An error response on the source port aborts the list with status bit 2 set. The beat that failed is never written.
- R8: An error response on the destination port aborts the list with status bit 3 set. No further request is issued after it.
- R9: A write with `cfg_sel`=1 clears each status bit whose data bit is 1 and leaves the other bits unchanged. If a status bit is set in the same cycle as a clear of that bit, the bit ends up set.
- R10: A start write while `busy` is high has no effect: exactly one walk and one interrupt occur.
- R11: A start write in the cycle in which `irq` is high is accepted. The next walk runs and the completion of the previous walk is still recorded.
- R12: A request that has not yet been acknowledged stays asserted on the next cycle, with its address (and its write data, for the destination port) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0 = start register (data is list base), 1 = status clear |
| cfg_wdata | input | 32 | Control write data |
| status | output | 5 | Sticky status: 4 desc err, 3 write err, 2 read err, 1 write done, 0 read done |
| irq | output | 1 | One-cycle done interrupt |
| busy | output | 1 | Walk in progress |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | 32 | Descriptor word address |
| dsc_ack | input | 1 | Descriptor read response |
| dsc_err | input | 1 | Descriptor read error, valid with ack |
| dsc_rdata | input | 32 | Descriptor word, valid with ack |
| src_req | output | 1 | Source read request |
| src_addr | output | 32 | Source address |
| src_ack | input | 1 | Source read response |
| src_err | input | 1 | Source read error, valid with ack |
| src_rdata | input | 32 | Source data, valid with ack |
| dst_req | output | 1 | Destination write request |
| dst_addr | output | 32 | Destination address |
| dst_wdata | output | 32 | Destination data |
| dst_ack | input | 1 | Destination write response |
| dst_err | input | 1 | Destination write error, valid with ack |

## Verification
The bench injects errors at chosen beats in the middle of a burst. It then counts the beats actually written, because a walker that aborts late writes one word too many, and one that aborts early leaves data missing. It builds chains in which a good element precedes a bad count, and it tests a count of zero and a count that is not a multiple of 256. A design that checks the count loosely would copy a partial element, and one that does not chain correctly would miss the bad element. It also issues a new start in the same cycle as the interrupt, and a status clear in that same cycle. A design that arbitrates either collision wrongly would drop the new walk or lose the completion bits. Random stalls on the responses exercise the request-hold rule.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH0, S_FETCH1, S_FETCH2, S_CHECK, S_COPY, S_NEXT, S_DONE
   } walk_state_t;

   typedef enum logic [1:0] {
      FLT_NONE, FLT_DESC, FLT_RD, FLT_WR
   } fault_t;

   localparam int ST_W       = 5;
   localparam int ST_RD_DONE = 0;
   localparam int ST_WR_DONE = 1;
   localparam int ST_RD_ERR  = 2;
   localparam int ST_WR_ERR  = 3;
   localparam int ST_SG_ERR  = 4;

endpackage

// File: rtl/sgw_status_reg.sv
module sgw_status_reg #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   input  logic [WIDTH-1:0] set_mask,
   output logic [WIDTH-1:0] status
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sgw_status_reg: WIDTH must be positive");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      // a set in the same cycle as a clear wins, so no event is dropped
      always_ff @(posedge clk) begin
         if (!rst_n)
            status[i] <= 1'b0;
         else if (set_mask[i])
            status[i] <= 1'b1;
         else if (clr_we && clr_mask[i])
            status[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/sgw_addr_gen.sv
module sgw_addr_gen #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int LAST_BIT  = 31,
   parameter int GRAN_LOG2 = 8,
   parameter int BEAT_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_base,
   input  logic [ADDR_W-1:0] base,
   input  logic              fetch_step,
   input  logic              ld_src,
   input  logic              ld_dst,
   input  logic              ld_ctl,
   input  logic              ld_beats,
   input  logic              beat_step,
   input  logic [DATA_W-1:0] word,
   output logic [ADDR_W-1:0] fetch_ptr,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic              last,
   output logic              cnt_bad,
   output logic              final_beat
);

   localparam int BEAT_W = CNT_W - BEAT_LOG2;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << BEAT_LOG2);

   if (GRAN_LOG2 < BEAT_LOG2 || GRAN_LOG2 >= CNT_W) begin : g_bad_gran
      $error("sgw_addr_gen: granule must hold whole beats and fit the count");
   end
   if (LAST_BIT < CNT_W || LAST_BIT >= DATA_W) begin : g_bad_last
      $error("sgw_addr_gen: last flag must sit above the count field");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [BEAT_W-1:0] beats_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_ptr <= '0;
         src_ptr   <= '0;
         dst_ptr   <= '0;
         cnt_q     <= '0;
         last      <= 1'b0;
         beats_q   <= '0;
      end else begin
         if (load_base)
            fetch_ptr <= base;
         else if (fetch_step)
            fetch_ptr <= fetch_ptr + STEP;
         if (ld_src)
            src_ptr <= ADDR_W'(word);
         else if (beat_step)
            src_ptr <= src_ptr + STEP;
         if (ld_dst)
            dst_ptr <= ADDR_W'(word);
         else if (beat_step)
            dst_ptr <= dst_ptr + STEP;
         if (ld_ctl) begin
            cnt_q <= word[CNT_W-1:0];
            last  <= word[LAST_BIT];
         end
         if (ld_beats)
            beats_q <= cnt_q[CNT_W-1:BEAT_LOG2];
         else if (beat_step)
            beats_q <= beats_q - BEAT_W'(1);
      end
   end

   assign cnt_bad    = (cnt_q == '0) || (cnt_q[GRAN_LOG2-1:0] != '0);
   assign final_beat = (beats_q == BEAT_W'(1));

endmodule

// File: rtl/sgw_fsm.sv
module sgw_fsm
   import sgw_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            dsc_ack,
   input  logic            dsc_err,
   input  logic            src_ack,
   input  logic            src_err,
   input  logic            dst_ack,
   input  logic            dst_err,
   input  logic            cnt_bad,
   input  logic            final_beat,
   input  logic            last,
   output logic            load_base,
   output logic            fetch_step,
   output logic            ld_src,
   output logic            ld_dst,
   output logic            ld_ctl,
   output logic            ld_beats,
   output logic            beat_step,
   output logic            dsc_req,
   output logic            src_req,
   output logic            dst_req,
   output logic            irq,
   output logic            busy,
   output logic [ST_W-1:0] set_mask
);

   walk_state_t state_q, state_d;
   fault_t      fault_q, fault_d;
   logic        wr_phase_q, wr_phase_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         fault_q    <= FLT_NONE;
         wr_phase_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         fault_q    <= fault_d;
         wr_phase_q <= wr_phase_d;
      end
   end

   always_comb begin
      state_d    = state_q;
      fault_d    = fault_q;
      wr_phase_d = wr_phase_q;
      load_base  = 1'b0;
      fetch_step = 1'b0;
      ld_src     = 1'b0;
      ld_dst     = 1'b0;
      ld_ctl     = 1'b0;
      ld_beats   = 1'b0;
      beat_step  = 1'b0;
      dsc_req    = 1'b0;
      src_req    = 1'b0;
      dst_req    = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (start) begin
               load_base = 1'b1;
               state_d   = S_FETCH0;
            end
         end
         S_FETCH0, S_FETCH1, S_FETCH2: begin
            dsc_req = 1'b1;
            if (dsc_ack) begin
               if (dsc_err) begin
                  fault_d = FLT_DESC;
                  state_d = S_DONE;
               end else begin
                  fetch_step = 1'b1;
                  ld_src     = (state_q == S_FETCH0);
                  ld_dst     = (state_q == S_FETCH1);
                  ld_ctl     = (state_q == S_FETCH2);
                  state_d    = (state_q == S_FETCH0) ? S_FETCH1 :
                               (state_q == S_FETCH1) ? S_FETCH2 : S_CHECK;
               end
            end
         end
         S_CHECK: begin
            if (cnt_bad) begin
               fault_d = FLT_DESC;
               state_d = S_DONE;
            end else begin
               ld_beats   = 1'b1;
               wr_phase_d = 1'b0;
               state_d    = S_COPY;
            end
         end
         S_COPY: begin
            if (!wr_phase_q) begin
               src_req = 1'b1;
               if (src_ack) begin
                  if (src_err) begin
                     fault_d = FLT_RD;
                     state_d = S_DONE;
                  end else begin
                     wr_phase_d = 1'b1;
                  end
               end
            end else begin
               dst_req = 1'b1;
               if (dst_ack) begin
                  if (dst_err) begin
                     fault_d = FLT_WR;
                     state_d = S_DONE;
                  end else begin
                     beat_step  = 1'b1;
                     wr_phase_d = 1'b0;
                     if (final_beat)
                        state_d = S_NEXT;
                  end
               end
            end
         end
         S_NEXT: begin
            if (last) begin
               fault_d = FLT_NONE;
               state_d = S_DONE;
            end else begin
               state_d = S_FETCH0;
            end
         end
         S_DONE: begin
            fault_d = FLT_NONE;
            if (start) begin
               load_base = 1'b1;
               state_d   = S_FETCH0;
            end else begin
               state_d   = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_comb begin
      set_mask = '0;
      if (state_q == S_DONE) begin
         unique case (fault_q)
            FLT_NONE: begin
               set_mask[ST_RD_DONE] = 1'b1;
               set_mask[ST_WR_DONE] = 1'b1;
            end
            FLT_DESC: set_mask[ST_SG_ERR] = 1'b1;
            FLT_RD:   set_mask[ST_RD_ERR] = 1'b1;
            FLT_WR:   set_mask[ST_WR_ERR] = 1'b1;
            default:  set_mask = '0;
         endcase
      end
   end

   assign irq  = (state_q == S_DONE);
   assign busy = (state_q != S_IDLE) && (state_q != S_DONE);

endmodule

// File: rtl/sg_walker.sv
module sg_walker
   import sgw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int LAST_BIT  = 31,
   parameter int GRAN_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [ST_W-1:0]   status,
   output logic              irq,
   output logic              busy,
   output logic              dsc_req,
   output logic [ADDR_W-1:0] dsc_addr,
   input  logic              dsc_ack,
   input  logic              dsc_err,
   input  logic [DATA_W-1:0] dsc_rdata,
   output logic              src_req,
   output logic [ADDR_W-1:0] src_addr,
   input  logic              src_ack,
   input  logic              src_err,
   input  logic [DATA_W-1:0] src_rdata,
   output logic              dst_req,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [DATA_W-1:0] dst_wdata,
   input  logic              dst_ack,
   input  logic              dst_err
);

   localparam int BEAT_LOG2 = $clog2(DATA_W / 8);

   if (ADDR_W != DATA_W) begin : g_bad_addr
      $error("sg_walker: descriptor words carry full addresses, ADDR_W must equal DATA_W");
   end
   if (DATA_W % 8 != 0 || (1 << BEAT_LOG2) * 8 != DATA_W) begin : g_bad_data
      $error("sg_walker: DATA_W must be a power-of-two number of bytes");
   end

   logic start, clr_we;
   logic load_base, fetch_step, ld_src, ld_dst, ld_ctl, ld_beats, beat_step;
   logic last, cnt_bad, final_beat;
   logic [ST_W-1:0]   set_mask;
   logic [DATA_W-1:0] data_q;

   assign start  = cfg_we && !cfg_sel;
   assign clr_we = cfg_we &&  cfg_sel;

   sgw_fsm i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .dsc_ack    (dsc_ack),
      .dsc_err    (dsc_err),
      .src_ack    (src_ack),
      .src_err    (src_err),
      .dst_ack    (dst_ack),
      .dst_err    (dst_err),
      .cnt_bad    (cnt_bad),
      .final_beat (final_beat),
      .last       (last),
      .load_base  (load_base),
      .fetch_step (fetch_step),
      .ld_src     (ld_src),
      .ld_dst     (ld_dst),
      .ld_ctl     (ld_ctl),
      .ld_beats   (ld_beats),
      .beat_step  (beat_step),
      .dsc_req    (dsc_req),
      .src_req    (src_req),
      .dst_req    (dst_req),
      .irq        (irq),
      .busy       (busy),
      .set_mask   (set_mask)
   );

   sgw_addr_gen #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .LAST_BIT  (LAST_BIT),
      .GRAN_LOG2 (GRAN_LOG2),
      .BEAT_LOG2 (BEAT_LOG2)
   ) i_addr_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_base  (load_base),
      .base       (ADDR_W'(cfg_wdata)),
      .fetch_step (fetch_step),
      .ld_src     (ld_src),
      .ld_dst     (ld_dst),
      .ld_ctl     (ld_ctl),
      .ld_beats   (ld_beats),
      .beat_step  (beat_step),
      .word       (dsc_rdata),
      .fetch_ptr  (dsc_addr),
      .src_ptr    (src_addr),
      .dst_ptr    (dst_addr),
      .last       (last),
      .cnt_bad    (cnt_bad),
      .final_beat (final_beat)
   );

   sgw_status_reg #(.WIDTH(ST_W)) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (clr_we),
      .clr_mask (cfg_wdata[ST_W-1:0]),
      .set_mask (set_mask),
      .status   (status)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         data_q <= '0;
      else if (src_req && src_ack && !src_err)
         data_q <= src_rdata;
   end

   assign dst_wdata = data_q;

endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ST_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dsc_req,
   input logic              dsc_ack,
   input logic [ADDR_W-1:0] dsc_addr,
   input logic              src_req,
   input logic              src_ack,
   input logic              src_err,
   input logic [ADDR_W-1:0] src_addr,
   input logic              dst_req,
   input logic              dst_ack,
   input logic [ADDR_W-1:0] dst_addr,
   input logic [DATA_W-1:0] dst_wdata,
   input logic              irq,
   input logic              busy,
   input logic [ST_W-1:0]   status
);

   AST_ONE_PORT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dsc_req, src_req, dst_req})); // R3

   AST_DSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_req && !dsc_ack |=> dsc_req && $stable(dsc_addr)); // R12

   AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      src_req && !src_ack |=> src_req && $stable(src_addr)); // R12

   AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dst_req && !dst_ack |=> dst_req && $stable(dst_addr) && $stable(dst_wdata)); // R12

   AST_WRITE_AFTER_GOOD_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dst_req) |-> $past(src_req && src_ack && !src_err)); // R3

   AST_READ_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      src_req && src_ack && src_err |=> !dst_req); // R7

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R4

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !dsc_req && !src_req && !dst_req); // R1

   AST_STATUS_SET_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status)) != '0 |-> $past(irq)); // R9

endmodule

bind sg_walker sg_walker_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .ST_W   (sgw_pkg::ST_W)
) i_sg_walker_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dsc_req   (dsc_req),
   .dsc_ack   (dsc_ack),
   .dsc_addr  (dsc_addr),
   .src_req   (src_req),
   .src_ack   (src_ack),
   .src_err   (src_err),
   .src_addr  (src_addr),
   .dst_req   (dst_req),
   .dst_ack   (dst_ack),
   .dst_addr  (dst_addr),
   .dst_wdata (dst_wdata),
   .irq       (irq),
   .busy      (busy),
   .status    (status)
);

// File: tb/test_sg_walker.sv
module test_sg_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [4:0]  status;
   logic        irq, busy;
   logic        dsc_req, src_req, dst_req;
   logic [31:0] dsc_addr, src_addr, dst_addr, dst_wdata;
   logic        dsc_ack, dsc_err, src_ack, src_err, dst_ack, dst_err;
   logic [31:0] dsc_rdata, src_rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   int irq_cnt = 0;

   logic [31:0] mem [0:4095];
   logic [31:0] bad_dsc = 32'hFFFF_FFF0;
   logic [31:0] bad_src = 32'hFFFF_FFF0;
   logic [31:0] bad_dst = 32'hFFFF_FFF0;
   logic        stall_en = 1'b0;
   logic [7:0]  lfsr = 8'h5B;
   logic        rdy;

   always #4 clk = ~clk;   // 125 MHz

   sg_walker i_sg_walker (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .status(status), .irq(irq), .busy(busy),
      .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack), .dsc_err(dsc_err), .dsc_rdata(dsc_rdata),
      .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack), .src_err(src_err), .src_rdata(src_rdata),
      .dst_req(dst_req), .dst_addr(dst_addr), .dst_wdata(dst_wdata), .dst_ack(dst_ack), .dst_err(dst_err)
   );

   // memory model: combinational responses, optionally stalled
   assign rdy       = stall_en ? lfsr[0] : 1'b1;
   assign dsc_ack   = dsc_req & rdy;
   assign dsc_err   = dsc_ack && (dsc_addr == bad_dsc);
   assign dsc_rdata = mem[dsc_addr[13:2]];
   assign src_ack   = src_req & rdy;
   assign src_err   = src_ack && (src_addr == bad_src);
   assign src_rdata = mem[src_addr[13:2]];
   assign dst_ack   = dst_req & rdy;
   assign dst_err   = dst_ack && (dst_addr == bad_dst);

   always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (dst_req && dst_ack && !dst_err) begin
         mem[dst_addr[13:2]] <= dst_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (src_req && src_ack) rd_cnt <= rd_cnt + 1;
      if (irq) irq_cnt <= irq_cnt + 1;
      if (cycles == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected=finish", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {16'hC0DE, a[15:0]} ^ 32'h0013_5700;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input logic [31:0] at, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] n, input bit lst);
      mem[at[13:2]]       = s;
      mem[at[13:2] + 1]   = d;
      mem[at[13:2] + 2]   = {lst, 15'h0, n};
   endtask

   task automatic prep(input logic [31:0] s, input logic [31:0] d, input int words);
      for (int i = 0; i < words; i++) begin
         mem[s[13:2] + 12'(i)] = pat(s + 32'(4*i));
         mem[d[13:2] + 12'(i)] = 32'hDEAD_BEEF;
      end
   endtask

   function automatic int copied(input logic [31:0] s, input logic [31:0] d, input int words);
      int good = 0;
      for (int i = 0; i < words; i++)
         if (mem[d[13:2] + 12'(i)] == pat(s + 32'(4*i))) good++;
      return good;
   endfunction

   task automatic cfg_write(input bit sel, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic fresh();
      cfg_write(1'b1, 32'h1F);
      bad_dsc = 32'hFFFF_FFF0; bad_src = 32'hFFFF_FFF0; bad_dst = 32'hFFFF_FFF0;
      wr_cnt = 0; rd_cnt = 0; irq_cnt = 0;
   endtask

   // returns at the negedge where irq is high
   task automatic wait_irq();
      int n = 0;
      while (!irq && n < 40000) begin
         @(negedge clk);
         n++;
      end
      chk(irq == 1'b1, "R4 irq reached", 32'(irq), 32'h1);
   endtask

   task automatic run(input logic [31:0] base);
      cfg_write(1'b0, base);
      wait_irq();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(status == 5'h0, "R1 status after reset", 32'(status), 32'h0);
      chk(!irq && !busy, "R1 irq/busy after reset", {30'h0, irq, busy}, 32'h0);
      chk(!dsc_req && !src_req && !dst_req, "R1 no requests after reset",
          {29'h0, dsc_req, src_req, dst_req}, 32'h0);
   endtask

   task automatic t_single();
      fresh();
      prep(32'h1000, 32'h2000, 64);
      put_desc(32'h0000, 32'h1000, 32'h2000, 16'h0100, 1'b1);
      run(32'h0000);
      chk(copied(32'h1000, 32'h2000, 64) == 64, "R3 single element data", 32'(copied(32'h1000, 32'h2000, 64)), 32'd64);
      chk(wr_cnt == 64 && rd_cnt == 64, "R3 beats for 256 bytes", 32'(wr_cnt), 32'd64);
      chk(status == 5'h03, "R4 completion bits", 32'(status), 32'h03);
      chk(!busy && irq_cnt == 1, "R4 single irq and idle", 32'(irq_cnt), 32'h1);
   endtask

   task automatic t_chain();
      fresh();
      stall_en = 1'b1;
      prep(32'h1000, 32'h2000, 64);
      prep(32'h1400, 32'h2800, 128);
      prep(32'h1C00, 32'h3000, 64);
      put_desc(32'h0040, 32'h1000, 32'h2000, 16'h0100, 1'b0);
      put_desc(32'h004C, 32'h1400, 32'h2800, 16'h0200, 1'b0);
      put_desc(32'h0058, 32'h1C00, 32'h3000, 16'h0100, 1'b1);
      run(32'h0040);
      stall_en = 1'b0;
      chk(copied(32'h1000, 32'h2000, 64) == 64, "R2 chain element 0", 32'(copied(32'h1000, 32'h2000, 64)), 32'd64);
      chk(copied(32'h1400, 32'h2800, 128) == 128, "R2 chain element 1 at base+12", 32'(copied(32'h1400, 32'h2800, 128)), 32'd128);
      chk(copied(32'h1C00, 32'h3000, 64) == 64, "R2 chain element 2 at base+24", 32'(copied(32'h1C00, 32'h3000, 64)), 32'd64);
      chk(wr_cnt == 256 && status == 5'h03 && irq_cnt == 1, "R4 chain stops at last flag", 32'(wr_cnt), 32'd256);
   endtask

   task automatic t_bad_count();
      fresh();
      prep(32'h1000, 32'h2000, 96);
      put_desc(32'h0080, 32'h1000, 32'h2000, 16'h0180, 1'b1);
      run(32'h0080);
      chk(status == 5'h10, "R5 count not multiple of 256", 32'(status), 32'h10);
      chk(rd_cnt == 0 && wr_cnt == 0, "R5 no data moved on bad count", 32'(rd_cnt + wr_cnt), 32'h0);
      fresh();
      put_desc(32'h0080, 32'h1000, 32'h2000, 16'h0000, 1'b1);
      run(32'h0080);
      chk(status == 5'h10 && wr_cnt == 0, "R5 zero count", 32'(status), 32'h10);
      fresh();
      prep(32'h1000, 32'h2000, 64);
      put_desc(32'h0080, 32'h1000, 32'h2000, 16'h0100, 1'b0);
      put_desc(32'h008C, 32'h1400, 32'h2800, 16'h0101, 1'b1);
      run(32'h0080);
      chk(wr_cnt == 64 && status == 5'h10, "R5 good element then bad one", 32'(wr_cnt), 32'd64);
   endtask

   task automatic t_dsc_err();
      fresh();
      prep(32'h1000, 32'h2000, 64);
      put_desc(32'h00C0, 32'h1000, 32'h2000, 16'h0100, 1'b1);
      bad_dsc = 32'h00C8;
      run(32'h00C0);
      chk(status == 5'h10 && rd_cnt == 0 && wr_cnt == 0, "R6 descriptor read error", 32'(status), 32'h10);
   endtask

   task automatic t_src_err();
      fresh();
      prep(32'h1000, 32'h2000, 256);
      put_desc(32'h0100, 32'h1000, 32'h2000, 16'h0400, 1'b1);
      bad_src = 32'h1000 + 32'd40;
      run(32'h0100);
      chk(status == 5'h04, "R7 read error bit", 32'(status), 32'h04);
      chk(wr_cnt == 10 && rd_cnt == 11, "R7 writes before failing beat", 32'(wr_cnt), 32'd10);
      chk(mem[(32'h2000 + 32'd40) >> 2] == 32'hDEAD_BEEF, "R7 failed beat not written",
          mem[(32'h2000 + 32'd40) >> 2], 32'hDEAD_BEEF);
   endtask

   task automatic t_dst_err();
      fresh();
      prep(32'h1000, 32'h2000, 256);
      put_desc(32'h0100, 32'h1000, 32'h2000, 16'h0400, 1'b1);
      bad_dst = 32'h2000 + 32'd20;
      run(32'h0100);
      chk(status == 5'h08, "R8 write error bit", 32'(status), 32'h08);
      chk(wr_cnt == 5 && rd_cnt == 6, "R8 no request after write error", 32'(rd_cnt), 32'd6);
   endtask

   task automatic t_w1c();
      fresh();
      prep(32'h1000, 32'h2000, 64);
      put_desc(32'h0000, 32'h1000, 32'h2000, 16'h0100, 1'b1);
      cfg_write(1'b0, 32'h0000);
      wait_irq();
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h1F;   // clear in the set cycle
      @(negedge clk);
      cfg_we = 1'b0;
      chk(status == 5'h03, "R9 set wins over same-cycle clear", 32'(status), 32'h03);
      cfg_write(1'b1, 32'h01);
      chk(status == 5'h02, "R9 clear only bit 0", 32'(status), 32'h02);
      cfg_write(1'b1, 32'h02);
      chk(status == 5'h00, "R9 clear bit 1", 32'(status), 32'h00);
   endtask

   task automatic t_busy_start();
      fresh();
      stall_en = 1'b1;
      prep(32'h1000, 32'h2000, 64);
      prep(32'h1400, 32'h3000, 64);
      put_desc(32'h0000, 32'h1000, 32'h2000, 16'h0100, 1'b1);
      put_desc(32'h0030, 32'h1400, 32'h3000, 16'h0100, 1'b1);
      cfg_write(1'b0, 32'h0000);
      repeat (10) @(negedge clk);
      chk(busy == 1'b1, "R10 walker busy", 32'(busy), 32'h1);
      cfg_write(1'b0, 32'h0030);
      wait_irq();
      stall_en = 1'b0;
      repeat (40) @(negedge clk);
      chk(irq_cnt == 1 && !busy, "R10 start while busy ignored", 32'(irq_cnt), 32'h1);
      chk(copied(32'h1400, 32'h3000, 64) == 0, "R10 second list untouched", 32'(copied(32'h1400, 32'h3000, 64)), 32'h0);
   endtask

   task automatic t_start_in_done();
      fresh();
      prep(32'h1000, 32'h2000, 64);
      prep(32'h1400, 32'h3000, 64);
      put_desc(32'h0000, 32'h1000, 32'h2000, 16'h0100, 1'b1);
      put_desc(32'h0030, 32'h1400, 32'h3000, 16'h0100, 1'b1);
      cfg_write(1'b0, 32'h0000);
      wait_irq();
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0030;
      @(negedge clk);
      cfg_we = 1'b0;
      chk(busy == 1'b1 && status == 5'h03, "R11 new start accepted, old completion kept",
          {27'h0, status}, 32'h03);
      wait_irq();
      @(negedge clk);
      chk(copied(32'h1400, 32'h3000, 64) == 64 && irq_cnt == 2, "R11 second list copied",
          32'(irq_cnt), 32'h2);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_chain();
      t_bad_count();
      t_dsc_err();
      t_src_err();
      t_dst_err();
      t_w1c();
      t_busy_start();
      t_start_in_done();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule